// File: doc/BRIEF.md
# Parallel EPROM Array Read Controller

This block is a synchronous bus master that turns single-byte read requests from a host into timed read cycles on a bank of byte-wide parallel EPROMs. Every device in the bank has an 18-bit address and an 8-bit data bus. The top host address bits pick one device. The block drives that device's active-low chip enable and holds every other chip enable high, so the unselected devices stay in standby. A single active-low output enable goes to all devices and acts as the read strobe.

Each read runs through a fixed sequence of named states. In IDLE, a request is accepted (IDLE→SETUP). SETUP drives the address and the decoded chip enable for one cycle. ADDR_WAIT lets the address age by the access time minus the output-enable access time (SETUP→ADDR_WAIT, or SETUP→OE_WAIT when no wait is needed). OE_WAIT pulls the output enable low for the output-enable access time (ADDR_WAIT→OE_WAIT). CAPTURE samples the data bus with the output enable still low (OE_WAIT→CAPTURE). FLOAT raises the output enable and waits out the bus float time (CAPTURE→FLOAT), and only then does the block return (FLOAT→IDLE). The cycle counts are the ceilings of the access, output-enable and float times divided by the clock period. The default values give 8, 3 and 3 cycles.

With chip-enable parking, which is the default, the last selected device keeps its chip enable low while the block is idle. A following read to the same device then toggles only the output enable, and still waits the full address time after the address changes. A read to a different device moves the chip enable at the accept edge. Because FLOAT has already passed, the old device is off the bus by then.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is low (asynchronous, active low), and after it is released, all `mem_ce_n` bits are 1, `mem_oe_n` is 1, and `busy` and `ack` are 0.
- R2: A request is accepted only at a clock edge where `busy` is 0 and `req` is 1. `busy` is then 1 for the 12 cycles that follow that edge (default timing). A `req` raised while `busy` is 1 is ignored and is not queued: no extra `ack` appears and `busy` stays 0 after the read.
- R3: Host address bits [19:18] select device d (0–3). From the cycle after the accept edge through CAPTURE, `mem_ce_n[d]` is 0, every other bit is 1, and `mem_addr` equals host address bits [17:0].
- R4: `mem_oe_n` goes low exactly 5 cycles after the address and chip enable are driven (the access count minus the output-enable count). While `busy` is 1, `mem_addr` and `mem_ce_n` do not change.
- R5: `mem_oe_n` stays low for 4 cycles (OE_WAIT and CAPTURE). The bus is sampled at the end of that window. `ack` is a one-cycle pulse in the 10th cycle after the accept edge, and during that pulse `rdata` holds the addressed byte.
- R6: After capture, `mem_oe_n` is 1 for 3 cycles (FLOAT) before `busy` falls. No chip enable falls in a cycle that follows a busy cycle.
- R7: With parking enabled, the selected device's chip enable stays low while idle and across consecutive reads to that device.
- R8: At most one `mem_ce_n` bit is 0 at any time. When the device changes, the old chip enable rises on the same edge as the new one falls. No two devices ever drive `mem_dq` at once.
- R9: `mem_oe_n` is 0 only while exactly one chip enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when idle |
| addr | input | 20 | Host byte address; [19:18] device, [17:0] offset |
| ack | output | 1 | One-cycle pulse, read data valid |
| rdata | output | 8 | Captured read byte |
| busy | output | 1 | A read cycle is in progress |
| mem_addr | output | 18 | Address to all devices |
| mem_ce_n | output | 4 | Active-low chip enable, one per device |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq | input | 8 | Data bus from the devices |

## Verification
A state that advances too early shows up as an output-enable fall or an `ack` earlier in the read than its fixed cycle. The bus model then returns X or high impedance, so the captured byte is wrong in that same read. A state that lingers shows up as a late `ack` or a `busy` that falls late, and this is seen within the 13 cycles of that read. A wrong select register or a wrong parking flag shows up on `mem_ce_n` in the first cycle after the accept edge, or as two devices driving at once. The bus model counts any such overlap.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_ADDR_WAIT,
        S_OE_WAIT,
        S_CAPTURE,
        S_FLOAT
    } rd_state_e;

    function automatic int cyc_ceil(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/rd_timer.sv
`timescale 1ns/1ps
module rd_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rd_ce_decode.sv
`timescale 1ns/1ps
module rd_ce_decode #(
    parameter int NUM_DEV = 4,
    parameter int SEL_W   = 2
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    output logic [NUM_DEV-1:0] ce_n
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_ce
        assign ce_n[i] = !(en && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int DEV_AW   = 18,
    parameter int DW       = 8,
    parameter int CLK_PS   = 20000,
    parameter int T_ACC_PS = 150000,
    parameter int T_OE_PS  = 60000,
    parameter int T_DF_PS  = 50000,
    parameter bit PARK_CE  = 1'b1,
    localparam int SEL_W   = $clog2(NUM_DEV),
    localparam int HAW     = DEV_AW + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [HAW-1:0]     addr,
    output logic               ack,
    output logic [DW-1:0]      rdata,
    output logic               busy,
    output logic [DEV_AW-1:0]  mem_addr,
    output logic [NUM_DEV-1:0] mem_ce_n,
    output logic               mem_oe_n,
    input  logic [DW-1:0]      mem_dq
);
    // cycle counts from the access-time parameters
    localparam int ACC_CYC = cyc_ceil(T_ACC_PS, CLK_PS);
    localparam int OE_CYC  = (cyc_ceil(T_OE_PS, CLK_PS) > 0) ? cyc_ceil(T_OE_PS, CLK_PS) : 1;
    localparam int DF_CYC  = (cyc_ceil(T_DF_PS, CLK_PS) > 0) ? cyc_ceil(T_DF_PS, CLK_PS) : 1;
    localparam int PRE_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
    localparam int W_ADDR  = (PRE_CYC > 1) ? PRE_CYC - 1 : 0;
    localparam int MAXC    = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
    localparam int TW      = $clog2(MAXC + 1);
    localparam logic [TW-1:0] LD_ADDR = TW'((W_ADDR > 0) ? W_ADDR - 1 : 0);
    localparam logic [TW-1:0] LD_OE   = TW'(OE_CYC - 1);
    localparam logic [TW-1:0] LD_DF   = TW'(DF_CYC - 1);

    rd_state_e          state_q, state_d;
    logic [DEV_AW-1:0]  addr_q;
    logic [SEL_W-1:0]   sel_q;
    logic               park_q;
    logic [DW-1:0]      rdata_q;
    logic               ack_q;
    logic               accept;
    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_zero;
    logic               ce_en;

    assign accept = (state_q == S_IDLE) && req;

    rd_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (req) state_d = S_SETUP;
            end
            S_SETUP: begin
                tmr_load = 1'b1;
                if (W_ADDR > 0) begin
                    state_d = S_ADDR_WAIT;
                    tmr_val = LD_ADDR;
                end else begin
                    state_d = S_OE_WAIT;
                    tmr_val = LD_OE;
                end
            end
            S_ADDR_WAIT: begin
                if (tmr_zero) begin
                    state_d  = S_OE_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_OE;
                end
            end
            S_OE_WAIT: begin
                if (tmr_zero) state_d = S_CAPTURE;
            end
            S_CAPTURE: begin
                state_d  = S_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = LD_DF;
            end
            S_FLOAT: begin
                if (tmr_zero) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request latch and capture path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            sel_q   <= '0;
            park_q  <= 1'b0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= (state_q == S_CAPTURE);
            if (accept) begin
                addr_q <= addr[DEV_AW-1:0];
                sel_q  <= addr[HAW-1:DEV_AW];
                park_q <= 1'b1;
            end
            if (state_q == S_CAPTURE) rdata_q <= mem_dq;
        end
    end

    if (PARK_CE) begin : g_park
        assign ce_en = park_q;
    end else begin : g_nopark
        assign ce_en = (state_q != S_IDLE);
    end

    rd_ce_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_dec (
        .sel  (sel_q),
        .en   (ce_en),
        .ce_n (mem_ce_n)
    );

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        mem_oe_n = !((state_q == S_OE_WAIT) || (state_q == S_CAPTURE));
        mem_addr = addr_q;
        ack      = ack_q;
        rdata    = rdata_q;
    end

    assert_single_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    assert_oe_needs_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> ($countones(~mem_ce_n) == 1));

    assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_in_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (busy && mem_oe_n));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_ce_n)));

    assert_ce_fall_after_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~mem_ce_n & $past(mem_ce_n))) |-> !$past(busy));
endmodule

// File: tb/eprom_rd_ctrl_tb.sv
`timescale 1ns/100ps
module eprom_rd_ctrl_tb;
    localparam int NDEV = 4;
    localparam real T_ACC = 150.0;
    localparam real T_OE  = 60.0;
    localparam real T_DF  = 50.0;
    localparam int ACC_C = (150 + 19) / 20;
    localparam int OE_C  = (60 + 19) / 20;
    localparam int DF_C  = (50 + 19) / 20;
    localparam int PRE   = ACC_C - OE_C;
    localparam int ACK_K = PRE + OE_C + 1;
    localparam int LEN   = ACK_K + DF_C;
    localparam int NV    = 10;

    localparam logic [19:0] VEC_ADDR [NV] = '{
        20'h00000, 20'h01234, 20'h01235, 20'h40010, 20'h8ABCD,
        20'hFFFFF, 20'hFFFFE, 20'h00001, 20'h7FFFF, 20'hB0000 };
    localparam logic [1:0] VEC_DEV [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [19:0] addr = '0;
    logic        ack, busy, mem_oe_n;
    logic [7:0]  rdata, dq_bus;
    logic [17:0] mem_addr;
    logic [3:0]  mem_ce_n;

    int checks = 0;
    int fails = 0;
    int contention = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    eprom_rd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .ack(ack),
        .rdata(rdata), .busy(busy), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_dq(dq_bus));

    function automatic logic [7:0] pat(input int d, input logic [17:0] a);
        return (a[7:0] ^ a[15:8]) + ({6'b0, a[17:16]} * 8'd17) + (8'(d) * 8'h5b);
    endfunction

    // device bank model
    realtime t_addr = 0.0;
    realtime t_oe_fall = 0.0;
    realtime t_ce_fall [NDEV];
    realtime t_rel [NDEV];
    logic [NDEV-1:0] prev_ce = '1;
    logic prev_oe = 1'b1;

    initial for (int d = 0; d < NDEV; d++) begin
        t_ce_fall[d] = 0.0;
        t_rel[d] = -1000.0;
    end

    always @(mem_addr) t_addr = $realtime;

    always @(mem_ce_n or mem_oe_n) begin
        for (int d = 0; d < NDEV; d++) begin
            if (prev_ce[d] === 1'b1 && mem_ce_n[d] === 1'b0) t_ce_fall[d] = $realtime;
            if (!prev_ce[d] && !prev_oe && !(!mem_ce_n[d] && !mem_oe_n)) t_rel[d] = $realtime;
        end
        if (prev_oe === 1'b1 && mem_oe_n === 1'b0) t_oe_fall = $realtime;
        prev_ce = mem_ce_n;
        prev_oe = mem_oe_n;
    end

    initial begin
        dq_bus = 'z;
        #0.5;
        forever begin
            int drivers;
            logic [7:0] v;
            drivers = 0;
            v = 'z;
            for (int d = 0; d < NDEV; d++) begin
                bit act;
                act = (mem_ce_n[d] === 1'b0) && (mem_oe_n === 1'b0);
                if (act || ($realtime - t_rel[d] < T_DF)) begin
                    drivers++;
                    if (act && ($realtime - t_addr >= T_ACC) && ($realtime - t_ce_fall[d] >= T_ACC)
                        && ($realtime - t_oe_fall >= T_OE))
                        v = pat(d, mem_addr);
                    else
                        v = 'x;
                end
            end
            if (drivers > 1) begin
                dq_bus = 'x;
                contention++;
            end else begin
                dq_bus = v;
            end
            #1;
        end
    end

    task automatic check(input bit ok, input string req_tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
        end
    endtask

    // one full read, entered at a negedge while idle; returns at the negedge of the last cycle
    task automatic do_read(input logic [19:0] a, input logic [1:0] dev, input bit poke);
        logic [15:0] oe_seq, busy_seq, ack_seq, oe_exp, busy_exp, ack_exp;
        logic [7:0] got;
        bit ce_bad, addr_bad;
        logic [3:0] exp_ce;
        oe_seq = '0; busy_seq = '0; ack_seq = '0;
        oe_exp = '0; busy_exp = '0; ack_exp = '0;
        got = '0; ce_bad = 0; addr_bad = 0;
        exp_ce = ~(4'b1 << dev);
        req = 1'b1;
        addr = a;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k <= LEN; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && k == 3) begin req = 1'b1; addr = a ^ 20'h40000; end
            if (poke && k == 6) req = 1'b0;
            oe_seq[k]   = mem_oe_n;
            busy_seq[k] = busy;
            ack_seq[k]  = ack;
            if (ack) got = rdata;
            if (mem_ce_n !== exp_ce) ce_bad = 1;
            if (k <= ACK_K - 1 && mem_addr !== a[17:0]) addr_bad = 1;
            oe_exp[k]   = !(k >= PRE && k < ACK_K);
            busy_exp[k] = (k < LEN);
            ack_exp[k]  = (k == ACK_K);
        end
        check(!ce_bad, "R3/R8", "chip enable pattern", {28'b0, mem_ce_n}, {28'b0, exp_ce});
        check(!addr_bad, "R3", "device address", {14'b0, mem_addr}, {14'b0, a[17:0]});
        check(oe_seq === oe_exp, "R4", "oe_n sequence", {16'b0, oe_seq}, {16'b0, oe_exp});
        check(ack_seq === ack_exp, "R5", "ack sequence", {16'b0, ack_seq}, {16'b0, ack_exp});
        check(got === pat(dev, a[17:0]), "R5", "read data", {24'b0, got}, {24'b0, pat(dev, a[17:0])});
        check(busy_seq === busy_exp, "R2/R6", "busy sequence", {16'b0, busy_seq}, {16'b0, busy_exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        check(mem_ce_n === 4'hF && mem_oe_n === 1'b1 && busy === 1'b0 && ack === 1'b0,
              "R1", "reset outputs", {26'b0, mem_ce_n, mem_oe_n, busy}, {26'b0, 4'hF, 2'b10});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_ce_n === 4'hF && mem_oe_n === 1'b1 && busy === 1'b0,
              "R1", "idle after reset", {27'b0, mem_ce_n, mem_oe_n}, {27'b0, 4'hF, 1'b1});

        // vector table: back-to-back reads, same and different devices
        for (int i = 0; i < NV; i++) do_read(VEC_ADDR[i], VEC_DEV[i], 1'b0);

        // R7: parked chip enable while idle
        repeat (3) @(negedge clk);
        check(mem_ce_n === ~(4'b1 << VEC_DEV[NV-1]) && mem_oe_n === 1'b1, "R7", "parked ce while idle",
              {28'b0, mem_ce_n}, {28'b0, ~(4'b1 << VEC_DEV[NV-1])});

        // R7: same device after an idle gap keeps chip enable low throughout
        do_read(20'h80042, 2'd2, 1'b0);

        // R2: request while busy is ignored and not queued
        do_read(20'h01111, 2'd0, 1'b1);
        begin
            bit extra;
            extra = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (busy || ack) extra = 1;
            end
            check(!extra, "R2", "request during busy ignored", {31'b0, extra}, 32'd0);
        end

        // R1: reset in the middle of a read with output enable low
        req = 1'b1;
        addr = 20'hC0123;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        repeat (PRE + 1) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(mem_ce_n === 4'hF && mem_oe_n === 1'b1 && busy === 1'b0 && ack === 1'b0,
              "R1", "mid-read reset", {26'b0, mem_ce_n, mem_oe_n, busy}, {26'b0, 4'hF, 2'b10});
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // recovery read to a fresh device
        do_read(20'h4FF00, 2'd1, 1'b0);

        // R8: never two devices on the bus
        check(contention == 0, "R8", "bus contention count", contention, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule